// File: doc/BRIEF.md
# Pad-to-channel interrupt mux

This block gathers interrupt requests from a large pool of GPIO pad inputs and routes a chosen few of them to a downstream interrupt controller. Eight output channels each pick one pad through a byte-wide select field. The chosen pad is synchronised and can be inverted. An optional glitch filter follows. The channel then either follows the level of the result or catches its rising edge in a sticky pending bit. Every request line is therefore active-high, so a controller that only accepts high levels and rising edges can also serve active-low and falling-edge sources.

Software sets the block up through a small register file on a plain 32-bit register bus, using a byte address, a write enable, write data and combinational read data. The pad pool size is a parameter. Select codes at or above the implemented pad count see a constant-low input.

Top module: `padmux_top`

## Requirements
- R1: Each of the 8 channels takes its 8-bit pad select from a packed register. Channels 0 to 3 use offset 0x04 and channels 4 to 7 use offset 0x08. Channel n's field sits at bits (n mod 4)*8 and up.
- R2: The register at offset 0x00 holds two bits per channel. Bit n chooses the trigger kind: 1 means edge, 0 means level. Bit 16+n inverts the selected input, which gives active-low level or falling-edge sensing.
- R3: The register at offset 0x0C holds a 4-bit filter length F for channel n at bits n*4 and up.
- R4: The selected pad passes through two synchronising flops. With F = 0 in level mode, a pad change sampled at clock edge k appears on the request line after edge k+1.
- R5: In level mode, the request equals the filtered, optionally inverted input. It stays high for as long as that input is high.
- R6: With F nonzero, the filtered signal changes only after the inverted input has differed from it for F consecutive clocks. A pad change sampled at edge k reaches a level request after edge k+1+F, and a pulse shorter than F clocks never passes.
- R7: In edge mode, a rising edge of the filtered signal sets a pending bit that drives the request. A falling pad edge counts as rising when the input is inverted. With F = 0, a pad change sampled at edge k raises the request after edge k+2. The bit stays set while the input returns to its idle level.
- R8: Writing to offset 0x10 clears pending bit n for every bit n of the write data that is 1. Pending bits whose write-data bit is 0 stay set.
- R9: Reads at offsets 0x00, 0x04, 0x08, 0x0C and 0x10 return the last value written there. Any other offset reads as 0.
- R10: While reset is high, all registers, pending bits and request lines are 0.
- R11: A select code at or above NUM_PADS reads as constant low: the request is 0 without inversion and 1 with inversion, whatever the pads do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pad_in | input | NUM_PADS | Asynchronous pad inputs |
| reg_addr | input | 5 | Register byte address |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| chan_req | output | 8 | Active-high request per channel |

## Verification
The hardest situation to reach from the ports is a pulse that gets partway through the filter and then vanishes. The filter counter must climb and then reset without ever flipping the output. The stimulus produces this by dropping a pad for exactly F-1 clocks under a settled filter of length F, then watching the request at every clock. The exact arrival cycle of a filtered change, and of an inverted falling edge in edge mode, is reached by changing a single pad on a known negative clock edge once the channel has settled.

// File: rtl/padmux_pkg.sv
package padmux_pkg;

    // Channel count is fixed by the packed register layout.
    localparam int NCH     = 8;
    localparam int SEL_W   = 8;
    localparam int FILT_W  = 4;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 5;
    localparam int POOL    = 1 << SEL_W;
    localparam int PER_REG = DATA_W / SEL_W;
    localparam int INV_POS = 16;

    localparam logic [ADDR_W-1:0] A_MODE   = 5'h00;
    localparam logic [ADDR_W-1:0] A_SEL_LO = 5'h04;
    localparam logic [ADDR_W-1:0] A_SEL_HI = 5'h08;
    localparam logic [ADDR_W-1:0] A_FILT   = 5'h0C;
    localparam logic [ADDR_W-1:0] A_CLR    = 5'h10;

    typedef enum logic {TRIG_LEVEL = 1'b0, TRIG_EDGE = 1'b1} trig_e;

    typedef struct packed {
        logic [SEL_W-1:0]  sel;
        logic [FILT_W-1:0] filt;
        trig_e             trig;
        logic              invert;
    } chan_cfg_t;

    function automatic chan_cfg_t build_cfg(
        input logic [NCH-1:0]    edge_bits,
        input logic [NCH-1:0]    inv_bits,
        input logic [DATA_W-1:0] sel_lo,
        input logic [DATA_W-1:0] sel_hi,
        input logic [DATA_W-1:0] filt_word,
        input int                ch
    );
        chan_cfg_t c;
        if (ch < PER_REG)
            c.sel = sel_lo[(ch % PER_REG) * SEL_W +: SEL_W];
        else
            c.sel = sel_hi[(ch % PER_REG) * SEL_W +: SEL_W];
        c.filt   = filt_word[ch * FILT_W +: FILT_W];
        c.trig   = trig_e'(edge_bits[ch]);
        c.invert = inv_bits[ch];
        return c;
    endfunction

endpackage

// File: rtl/padmux_regs.sv
module padmux_regs
    import padmux_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [NCH-1:0]    edge_bits,
    output logic [NCH-1:0]    inv_bits,
    output logic [DATA_W-1:0] sel_lo,
    output logic [DATA_W-1:0] sel_hi,
    output logic [DATA_W-1:0] filt_word,
    output logic [NCH-1:0]    clr_strobe
);
    logic [DATA_W-1:0] mode_q, sel_lo_q, sel_hi_q, filt_q, clr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= '0;
            sel_lo_q <= '0;
            sel_hi_q <= '0;
            filt_q   <= '0;
            clr_q    <= '0;
        end else if (we) begin
            case (addr)
                A_MODE:   mode_q   <= wdata;
                A_SEL_LO: sel_lo_q <= wdata;
                A_SEL_HI: sel_hi_q <= wdata;
                A_FILT:   filt_q   <= wdata;
                A_CLR:    clr_q    <= wdata;
                default:  ;
            endcase
        end
    end

    always_comb begin
        case (addr)
            A_MODE:   rdata = mode_q;
            A_SEL_LO: rdata = sel_lo_q;
            A_SEL_HI: rdata = sel_hi_q;
            A_FILT:   rdata = filt_q;
            A_CLR:    rdata = clr_q;
            default:  rdata = '0;
        endcase
    end

    assign edge_bits  = mode_q[NCH-1:0];
    assign inv_bits   = mode_q[INV_POS +: NCH];
    assign sel_lo     = sel_lo_q;
    assign sel_hi     = sel_hi_q;
    assign filt_word  = filt_q;
    assign clr_strobe = (we && addr == A_CLR) ? wdata[NCH-1:0] : '0;

    // R9: a write to the filter register is visible on the next read
    a_r9_filt_readback: assert property (@(posedge clk) disable iff (rst)
        (we && addr == A_FILT) |=> (filt_word == $past(wdata)));

    // R1: a write to the low select register lands unchanged
    a_r1_sel_lo_store: assert property (@(posedge clk) disable iff (rst)
        (we && addr == A_SEL_LO) |=> (sel_lo == $past(wdata)));

endmodule

// File: rtl/padmux_filter.sv
module padmux_filter
    import padmux_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              din,
    input  logic [FILT_W-1:0] limit,
    output logic              dout
);
    logic              q;
    logic [FILT_W-1:0] cnt;
    logic              bypass;

    assign bypass = (limit == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            q   <= 1'b0;
            cnt <= '0;
        end else if (bypass) begin
            q   <= din;
            cnt <= '0;
        end else if (din == q) begin
            cnt <= '0;
        end else if (cnt >= limit - 1'b1) begin
            q   <= din;
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign dout = bypass ? din : q;

    // R6: with the filter active, an input that agrees with the held value leaves it untouched
    a_r6_hold_when_equal: assert property (@(posedge clk) disable iff (rst)
        (!bypass && din == q) |=> $stable(q));

    // R6: the held value never moves without a full run of differing cycles when the limit exceeds one
    a_r6_no_early_flip: assert property (@(posedge clk) disable iff (rst)
        (limit > 4'd1 && $past(limit) == limit && !$past(bypass) && $past(din) != $past(q) && $past(cnt) == '0 && din == $past(din))
        |-> (q == $past(q)));

endmodule

// File: rtl/padmux_chan.sv
module padmux_chan
    import padmux_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [POOL-1:0] pad_pool,
    input  chan_cfg_t       cfg,
    input  logic            clr,
    output logic            req
);
    logic pad_raw;
    logic sync1, sync2;
    logic inv_sig;
    logic filt_sig;
    logic prev_q;
    logic rise;
    logic pend_q;

    assign pad_raw = pad_pool[cfg.sel];

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1 <= 1'b0;
            sync2 <= 1'b0;
        end else begin
            sync1 <= pad_raw;
            sync2 <= sync1;
        end
    end

    assign inv_sig = sync2 ^ cfg.invert;

    padmux_filter i_filter (
        .clk   (clk),
        .rst   (rst),
        .din   (inv_sig),
        .limit (cfg.filt),
        .dout  (filt_sig)
    );

    assign rise = filt_sig & ~prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            prev_q <= filt_sig;
            pend_q <= (pend_q & ~clr) | (rise & (cfg.trig == TRIG_EDGE));
        end
    end

    assign req = (cfg.trig == TRIG_EDGE) ? pend_q : filt_sig;

    // R8: a pending bit survives every cycle without a clear
    a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
        (pend_q && !clr) |=> pend_q);

    // R8: a clear with no competing edge drops the pending bit
    a_r8_clear_drops: assert property (@(posedge clk) disable iff (rst)
        (clr && !(rise && cfg.trig == TRIG_EDGE)) |=> !pend_q);

    // R7: a pending bit only appears after a rising edge in edge mode
    a_r7_set_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(pend_q) |-> $past(rise && cfg.trig == TRIG_EDGE));

endmodule

// File: rtl/padmux_top.sv
module padmux_top
    import padmux_pkg::*;
#(
    parameter int NUM_PADS = 256
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PADS-1:0] pad_in,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic                reg_we,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic [NCH-1:0]      chan_req
);
    logic [NCH-1:0]    edge_bits, inv_bits, clr_strobe;
    logic [DATA_W-1:0] sel_lo, sel_hi, filt_word;
    logic [POOL-1:0]   pad_pool;

    padmux_regs i_regs (
        .clk        (clk),
        .rst        (rst),
        .addr       (reg_addr),
        .we         (reg_we),
        .wdata      (reg_wdata),
        .rdata      (reg_rdata),
        .edge_bits  (edge_bits),
        .inv_bits   (inv_bits),
        .sel_lo     (sel_lo),
        .sel_hi     (sel_hi),
        .filt_word  (filt_word),
        .clr_strobe (clr_strobe)
    );

    // R11: codes beyond the implemented pads see tied-low inputs
    generate
        if (NUM_PADS < POOL) begin : g_pad_pad
            assign pad_pool = {{(POOL - NUM_PADS){1'b0}}, pad_in};
        end else begin : g_pad_full
            assign pad_pool = pad_in[POOL-1:0];
        end
    endgenerate

    generate
        for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
            chan_cfg_t cfg;
            assign cfg = build_cfg(edge_bits, inv_bits, sel_lo, sel_hi, filt_word, ch);
            padmux_chan i_chan (
                .clk      (clk),
                .rst      (rst),
                .pad_pool (pad_pool),
                .cfg      (cfg),
                .clr      (clr_strobe[ch]),
                .req      (chan_req[ch])
            );
        end
    endgenerate

    // R10: the cycle after a reset edge every request is low
    a_r10_reset_quiet: assert property (@(posedge clk)
        rst |=> (chan_req == '0));

    // R10: the read port shows zero for the mode register right after reset
    a_r10_reset_regs: assert property (@(posedge clk)
        (rst && reg_addr == A_MODE) |=> (reg_addr != A_MODE || reg_rdata == '0 || $past(reg_we)));

endmodule

// File: tb/test_padmux_top.sv
module test_padmux_top;
    import padmux_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NP = 24;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NP-1:0]     pad_in = '0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic              reg_we = 1'b0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [DATA_W-1:0] reg_rdata;
    logic [NCH-1:0]    chan_req;

    padmux_top #(.NUM_PADS(NP)) i_padmux_top (
        .clk       (clk),
        .rst       (rst),
        .pad_in    (pad_in),
        .reg_addr  (reg_addr),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .chan_req  (chan_req)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [31:0] sh_mode = '0, sh_lo = '0, sh_hi = '0, sh_filt = '0;

    // Vector rows: {channel[3], select[8], invert[1], pad level[1]}
    localparam int NV = 9;
    localparam logic [12:0] VEC [NV] = '{
        {3'd0, 8'd3,  1'b0, 1'b1},
        {3'd0, 8'd3,  1'b0, 1'b0},
        {3'd5, 8'd17, 1'b1, 1'b0},
        {3'd5, 8'd17, 1'b1, 1'b1},
        {3'd3, 8'd23, 1'b0, 1'b1},
        {3'd7, 8'd0,  1'b1, 1'b1},
        {3'd4, 8'd9,  1'b0, 1'b1},
        {3'd2, 8'd30, 1'b0, 1'b1},
        {3'd2, 8'd30, 1'b1, 1'b0}
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_we    = 1'b1;
        step(1);
        reg_we    = 1'b0;
    endtask

    task automatic rd_check(input logic [ADDR_W-1:0] a, input logic [31:0] exp, input string tag);
        reg_addr = a;
        #1;
        check(reg_rdata == exp, tag, reg_rdata, exp);
    endtask

    task automatic cfg_chan(input int ch, input logic [7:0] sel, input bit edge_m,
                            input bit inv, input logic [3:0] f);
        if (ch < 4) sh_lo[(ch % 4) * 8 +: 8] = sel;
        else        sh_hi[(ch % 4) * 8 +: 8] = sel;
        sh_mode[ch]      = edge_m;
        sh_mode[16 + ch] = inv;
        sh_filt[ch * 4 +: 4] = f;
        wr(A_SEL_LO, sh_lo);
        wr(A_SEL_HI, sh_hi);
        wr(A_MODE, sh_mode);
        wr(A_FILT, sh_filt);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int drops;
        step(3);
        // R10: state during reset
        check(chan_req == '0, "R10 req in reset", chan_req, 0);
        rd_check(A_MODE, 0, "R10 mode reg in reset");
        rd_check(A_FILT, 0, "R10 filt reg in reset");
        rst = 1'b0;
        step(2);

        // R9: readback of every register, unmapped offset zero
        wr(A_CLR, 32'hA5A5_0F0F);
        rd_check(A_CLR, 32'hA5A5_0F0F, "R9 clear reg readback");
        wr(A_SEL_LO, 32'h1122_3344);
        rd_check(A_SEL_LO, 32'h1122_3344, "R9 R1 sel_lo readback");
        rd_check(5'h14, 0, "R9 unmapped read");
        wr(A_SEL_LO, 32'h0);
        wr(A_CLR, 32'h0);

        // R1 R2 R5 R11: vector walk in level mode, filter off
        for (int i = 0; i < NV; i++) begin
            int ch; logic [7:0] sel; bit inv; bit pv; bit exp;
            ch  = int'(VEC[i][12:10]);
            sel = VEC[i][9:2];
            inv = VEC[i][1];
            pv  = VEC[i][0];
            cfg_chan(ch, sel, 1'b0, inv, 4'd0);
            pad_in = pv ? '0 : '1;
            if (int'(sel) < NP) pad_in[sel] = pv;
            step(4);
            exp = ((int'(sel) < NP) ? pv : 1'b0) ^ inv;
            check(chan_req[ch] == exp, $sformatf("R1 R5 R11 vector %0d", i), chan_req[ch], exp);
        end

        // R4: two-flop latency with filter off
        pad_in = '0;
        cfg_chan(1, 8'd5, 1'b0, 1'b0, 4'd0);
        step(4);
        pad_in[5] = 1'b1;
        step(1);
        check(chan_req[1] == 1'b0, "R4 not yet after one edge", chan_req[1], 0);
        step(1);
        check(chan_req[1] == 1'b1, "R4 arrives after second edge", chan_req[1], 1);

        // R3 R6: filter length 3 delays the change to edge k+4
        pad_in[5] = 1'b0;
        cfg_chan(1, 8'd5, 1'b0, 1'b0, 4'd3);
        step(10);
        check(chan_req[1] == 1'b0, "R6 settled low", chan_req[1], 0);
        pad_in[5] = 1'b1;
        step(4);
        check(chan_req[1] == 1'b0, "R6 held before F stable clocks", chan_req[1], 0);
        step(1);
        check(chan_req[1] == 1'b1, "R3 R6 passes after F stable clocks", chan_req[1], 1);

        // R6: a two-clock dip under F=3 is swallowed
        step(4);
        drops = 0;
        pad_in[5] = 1'b0;
        for (int j = 0; j < 12; j++) begin
            if (j == 2) pad_in[5] = 1'b1;
            step(1);
            if (chan_req[1] != 1'b1) drops++;
        end
        check(drops == 0, "R6 short glitch rejected", drops, 0);

        // R7: inverted edge channel catches a falling pad edge
        pad_in[8] = 1'b1;
        cfg_chan(6, 8'd8, 1'b1, 1'b1, 4'd0);
        step(5);
        wr(A_CLR, 32'h40);
        step(2);
        check(chan_req[6] == 1'b0, "R7 R8 idle edge channel", chan_req[6], 0);
        pad_in[8] = 1'b0;
        step(2);
        check(chan_req[6] == 1'b0, "R7 not yet after two edges", chan_req[6], 0);
        step(1);
        check(chan_req[6] == 1'b1, "R7 pending after third edge", chan_req[6], 1);
        pad_in[8] = 1'b1;
        step(6);
        check(chan_req[6] == 1'b1, "R7 sticky after pad returns", chan_req[6], 1);

        // R8: clear with bit 6 low keeps it, with bit 6 high drops it
        wr(A_CLR, 32'hBF);
        check(chan_req[6] == 1'b1, "R8 other bits do not clear", chan_req[6], 1);
        wr(A_CLR, 32'h40);
        check(chan_req[6] == 1'b0, "R8 clear drops pending", chan_req[6], 0);

        // R10: reset mid-run clears registers and requests
        pad_in = '1;
        rst = 1'b1;
        step(2);
        check(chan_req == '0, "R10 req cleared by reset", chan_req, 0);
        rd_check(A_SEL_HI, 0, "R10 sel_hi cleared by reset");
        rst = 1'b0;
        step(1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule